// File: doc/BRIEF.md
# Multi-core I2C register slave

This block is an I2C target, good for standard and fast mode, that sits in front of four identical register-bank cores. A master writes a sub-address and then a run of data bytes. The sub-address advances after every byte, so a single transaction fills consecutive registers. Reads take two transactions. A write transaction sets the sub-address and ends with a stop. A second transaction then carries the read bit, and the slave returns bytes until the master answers with a NACK.

Two local registers decide which cores see the traffic. The broadcast mask lets one write reach any subset of the cores at once. The read selector names the core that answers reads, and the lowest set bit wins if several are set. Writing either register clears the other, so the two modes never overlap. The low two bits of the device address come from two strap pins, captured on the first clock after reset is released.

A core that cannot take a write raises its busy line. If any addressed core is busy, the slave holds SCL low in the acknowledge slot and releases it once the write strobe has been issued.

Top module: `i2c_multicore_slave`

## Requirements
- R1: The 7-bit device address is {5'b10111, strap}, using the strap pins as captured on the first clock after reset release. A header byte with any other address is not acknowledged, and the transaction has no effect.
- R2: SDA falling while SCL is high starts a transaction. SDA rising while SCL is high ends it and discards any partly received byte. The slave changes its own SDA drive only while SCL is low.
- R3: In a write (R/W bit 0), the first byte after the address is the sub-address and each later byte goes to the current sub-address, which then increments. The slave acknowledges every byte.
- R4: Each data byte whose sub-address is neither 0xFE nor 0xFF produces a single-cycle pulse on wr_strobe_o. The pulse has bit k set for each core k enabled in the mask, and wr_addr_o and wr_data_o are held valid during it. If the mask is zero, no pulse is produced.
- R5: Sub-address 0xFE is the broadcast mask: bits [3:0], with bit k enabling core k. It resets to 0x0F and reads back through sub-address 0xFE.
- R6: A write to 0xFE clears the selector to 0x00, and a write to 0xFF clears the mask to 0x00, whatever value is written.
- R7: Sub-address 0xFF is the read selector: bits [3:0], reset 0x00. Reads of other sub-addresses return core data from the lowest-numbered set bit, or 0xFF when the selector is zero.
- R8: If a core enabled in the mask is busy when a data byte completes, SCL is held low in that byte's acknowledge slot. The strobe is issued only after all enabled cores are not busy, and SCL is then released. Busy lines of cores outside the mask never hold SCL.
- R9: A read (R/W bit 1) returns bytes starting at the stored sub-address, MSB first, incrementing after each byte. It continues while the master acknowledges and stops after a NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low (ack or read data 0) |
| strap_i | input | 2 | Address strap pins |
| core_busy_i | input | NCORE | Per-core busy |
| wr_strobe_o | output | NCORE | Per-core write pulse |
| wr_addr_o | output | 8 | Write register address |
| wr_data_o | output | 8 | Write data |
| rd_addr_o | output | 8 | Read register address to all cores |
| rd_data_i | input | NCORE*8 | Read data, core k in bits [8k+7:8k] |

## Verification
A write can be held back by a busy core. The strobe that releases it then lands in the same cycle that the slave lets go of SCL, while the master is still waiting on the held clock. The bench keeps a masked core busy through a long hold and checks that SCL stays low and no strobe appears. It then drops busy and checks that exactly one strobe arrives and that the byte reaches the right register. A second case makes only a core outside the mask busy and checks that SCL is never held.

// File: rtl/i2c_mc_pkg.sv
package i2c_mc_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} bus_st_e;
  typedef enum logic [1:0] {PH_ADDR, PH_SUB, PH_DATA, PH_READ} phase_e;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/i2c_mc_sync.sv
module i2c_mc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_mc_route.sv
module i2c_mc_route #(
  parameter int unsigned NCORE    = 4,
  parameter logic [7:0]  MASK_SUB = 8'hFE,
  parameter logic [7:0]  SEL_SUB  = 8'hFF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_valid_i,
  input  logic [7:0]           wr_sub_i,
  input  logic [7:0]           wr_byte_i,
  input  logic [NCORE-1:0]     core_busy_i,
  input  logic [7:0]           rd_sub_i,
  input  logic [NCORE*8-1:0]   rd_data_i,
  output logic [7:0]           rd_byte_o,
  output logic                 pending_o,
  output logic [NCORE-1:0]     strobe_o,
  output logic [7:0]           addr_o,
  output logic [7:0]           data_o
);
  localparam int unsigned PAD = 8 - NCORE;

  logic [NCORE-1:0] mask_q, sel_q;
  logic [7:0]       core_rd [NCORE];
  logic [7:0]       sel_byte;
  logic             sel_found;
  logic             blocked;

  for (genvar k = 0; k < NCORE; k++) begin : g_rd
    assign core_rd[k] = rd_data_i[k*8 +: 8];
  end

  // lowest set selector bit wins
  always_comb begin
    sel_byte  = 8'hFF;
    sel_found = 1'b0;
    for (int k = 0; k < NCORE; k++) begin
      if (sel_q[k] && !sel_found) begin
        sel_byte  = core_rd[k];
        sel_found = 1'b1;
      end
    end
  end

  always_comb begin
    if (rd_sub_i == MASK_SUB)     rd_byte_o = {{PAD{1'b0}}, mask_q};
    else if (rd_sub_i == SEL_SUB) rd_byte_o = {{PAD{1'b0}}, sel_q};
    else                          rd_byte_o = sel_byte;
  end

  assign blocked = |(core_busy_i & mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '1;
      sel_q     <= '0;
      pending_o <= 1'b0;
      strobe_o  <= '0;
      addr_o    <= '0;
      data_o    <= '0;
    end else begin
      strobe_o <= '0;
      if (pending_o && !blocked) begin
        strobe_o  <= mask_q;
        pending_o <= 1'b0;
      end
      if (wr_valid_i) begin
        if (wr_sub_i == MASK_SUB) begin
          mask_q <= wr_byte_i[NCORE-1:0];
          sel_q  <= '0;
        end else if (wr_sub_i == SEL_SUB) begin
          sel_q  <= wr_byte_i[NCORE-1:0];
          mask_q <= '0;
        end else if (|mask_q) begin
          pending_o <= 1'b1;
          addr_o    <= wr_sub_i;
          data_o    <= wr_byte_i;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_multicore_slave.sv
module i2c_multicore_slave
  import i2c_mc_pkg::*;
#(
  parameter int unsigned NCORE       = 4,
  parameter logic [6:0]  ADDR_BASE   = 7'h5C,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  MASK_SUB    = 8'hFE,
  parameter logic [7:0]  SEL_SUB     = 8'hFF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 scl_oe_o,
  output logic                 sda_oe_o,
  input  logic [1:0]           strap_i,
  input  logic [NCORE-1:0]     core_busy_i,
  output logic [NCORE-1:0]     wr_strobe_o,
  output logic [BYTE_W-1:0]    wr_addr_o,
  output logic [BYTE_W-1:0]    wr_data_o,
  output logic [BYTE_W-1:0]    rd_addr_o,
  input  logic [NCORE*8-1:0]   rd_data_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_mc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  bus_st_e     state_q;
  phase_e      phase_q;
  logic [7:0]  shreg_q, tx_q, sub_q, wr_sub_q, wr_byte_q;
  logic [3:0]  bitcnt_q;
  logic        ack_q, mack_q, wr_valid_q;
  logic [1:0]  strap_q;
  logic        strap_done_q;
  logic [7:0]  rx_byte, rd_byte;
  logic [6:0]  dev_addr;
  logic        pending;

  assign rx_byte  = {shreg_q[6:0], sda_s};
  assign dev_addr = {ADDR_BASE[6:2], strap_q};

  i2c_mc_route #(.NCORE(NCORE), .MASK_SUB(MASK_SUB), .SEL_SUB(SEL_SUB)) u_route (
    .clk_i, .rst_ni,
    .wr_valid_i(wr_valid_q), .wr_sub_i(wr_sub_q), .wr_byte_i(wr_byte_q),
    .core_busy_i, .rd_sub_i(sub_q), .rd_data_i, .rd_byte_o(rd_byte),
    .pending_o(pending), .strobe_o(wr_strobe_o), .addr_o(wr_addr_o), .data_o(wr_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      phase_q      <= PH_ADDR;
      shreg_q      <= '0;
      tx_q         <= '0;
      sub_q        <= '0;
      wr_sub_q     <= '0;
      wr_byte_q    <= '0;
      bitcnt_q     <= '0;
      ack_q        <= 1'b0;
      mack_q       <= 1'b0;
      wr_valid_q   <= 1'b0;
      strap_q      <= '0;
      strap_done_q <= 1'b0;
    end else begin
      wr_valid_q <= 1'b0;
      if (!strap_done_q) begin
        strap_q      <= strap_i;
        strap_done_q <= 1'b1;
      end
      if (bus_start) begin
        state_q  <= ST_RX;
        phase_q  <= PH_ADDR;
        bitcnt_q <= '0;
      end else if (bus_stop) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise) begin
              shreg_q  <= rx_byte;
              bitcnt_q <= bitcnt_q + 4'd1;
              if (bitcnt_q == 4'd7) begin
                ack_q <= 1'b1;
                unique case (phase_q)
                  PH_ADDR: begin
                    if (rx_byte[7:1] == dev_addr) phase_q <= rx_byte[0] ? PH_READ : PH_SUB;
                    else                          ack_q   <= 1'b0;
                  end
                  PH_SUB: begin
                    sub_q   <= rx_byte;
                    phase_q <= PH_DATA;
                  end
                  PH_DATA: begin
                    wr_valid_q <= 1'b1;
                    wr_sub_q   <= sub_q;
                    wr_byte_q  <= rx_byte;
                    sub_q      <= sub_q + 8'd1;
                  end
                  default: ack_q <= 1'b0;
                endcase
              end
            end else if (scl_fall && bitcnt_q == 4'd8) begin
              state_q  <= ST_ACK;
              bitcnt_q <= '0;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (!ack_q) begin
                state_q <= ST_IDLE;
              end else if (phase_q == PH_READ) begin
                tx_q    <= rd_byte;
                sub_q   <= sub_q + 8'd1;
                state_q <= ST_TX;
              end else begin
                state_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              tx_q     <= {tx_q[6:0], 1'b0};
              bitcnt_q <= bitcnt_q + 4'd1;
              if (bitcnt_q == 4'd7) begin
                state_q  <= ST_MACK;
                bitcnt_q <= '0;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            if (scl_fall) begin
              if (mack_q) begin
                tx_q    <= rd_byte;
                sub_q   <= sub_q + 8'd1;
                state_q <= ST_TX;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr_o = sub_q;
  assign sda_oe_o  = (state_q == ST_ACK && ack_q) || (state_q == ST_TX && !tx_q[7]);
  // stretch only inside the acknowledge slot, SCL already low
  assign scl_oe_o  = (state_q == ST_ACK) && pending;
endmodule

// File: rtl/i2c_mc_checker.sv
module i2c_mc_checker #(
  parameter int unsigned NCORE = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_s,
  input logic             sda_oe_o,
  input logic             scl_oe_o,
  input logic [NCORE-1:0] wr_strobe_o,
  input logic [NCORE-1:0] core_busy_i,
  input logic [7:0]       wr_addr_o
);
  p_sda_change_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);

  p_strobe_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_strobe_o != '0) |=> (wr_strobe_o == '0));

  p_addr_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_strobe_o != '0) |-> $stable(wr_addr_o));

  p_strobe_not_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_strobe_o != '0) |-> (($past(core_busy_i) & wr_strobe_o) == '0));

  p_stretch_scl_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> !scl_s);

  p_no_strobe_in_stretch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> (wr_strobe_o == '0));
endmodule

bind i2c_multicore_slave i2c_mc_checker #(.NCORE(NCORE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .scl_oe_o(scl_oe_o), .wr_strobe_o(wr_strobe_o), .core_busy_i(core_busy_i),
  .wr_addr_o(wr_addr_o)
);

// File: tb/tb_i2c_multicore_slave.sv
module tb_i2c_multicore_slave;
  localparam int Q = 8;
  localparam logic [7:0] FE = 8'hFE;
  localparam logic [7:0] FF = 8'hFF;
  // {mask, sub, data}
  localparam logic [19:0] VEC [6] = '{
    {4'b0001, 8'h10, 8'hA5}, {4'b1000, 8'h11, 8'h3C}, {4'b0101, 8'h12, 8'h77},
    {4'b1111, 8'h13, 8'h0F}, {4'b0000, 8'h14, 8'hEE}, {4'b1010, 8'h10, 8'h5A}};

  logic clk = 0, rst_n = 0;
  logic m_scl_lo = 0, m_sda_lo = 0;
  logic scl_bus, sda_bus, scl_oe, sda_oe;
  logic [1:0] strap = 2'b00;
  logic [3:0] busy = '0, strobe;
  logic [7:0] wr_addr, wr_data, rd_addr;
  logic [31:0] rd_data;
  logic [7:0] mem [4][256];
  logic [7:0] expm [4][256];
  logic [6:0] dev = 7'h5C;
  int n_chk = 0, n_bad = 0, n_strobe = 0;
  logic saw_stretch = 0;

  always #5 clk = ~clk;
  assign scl_bus = !(m_scl_lo || scl_oe);
  assign sda_bus = !(m_sda_lo || sda_oe);

  i2c_multicore_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .strap_i(strap), .core_busy_i(busy),
    .wr_strobe_o(strobe), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data));

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) for (int a = 0; a < 256; a++) mem[k][a] <= 8'h00;
    end else begin
      for (int k = 0; k < 4; k++) if (strobe[k]) mem[k][wr_addr] <= wr_data;
      if (strobe != 0) n_strobe <= n_strobe + 1;
      if (scl_oe) saw_stretch <= 1'b1;
    end
  end

  always_comb for (int k = 0; k < 4; k++) rd_data[k*8 +: 8] = mem[k][rd_addr];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    m_sda_lo = !b; tick(Q);
    m_scl_lo = 0; while (!scl_bus) tick(1);
    tick(Q); m_scl_lo = 1; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_sda_lo = 0; tick(Q);
    m_scl_lo = 0; while (!scl_bus) tick(1);
    tick(Q/2); b = sda_bus; tick(Q/2);
    m_scl_lo = 1; tick(Q);
  endtask

  task automatic i2c_start();
    m_sda_lo = 0; m_scl_lo = 0; tick(Q);
    m_sda_lo = 1; tick(Q);
    m_scl_lo = 1; tick(Q);
  endtask

  task automatic i2c_stop();
    m_sda_lo = 1; tick(Q);
    m_scl_lo = 0; while (!scl_bus) tick(1);
    tick(Q); m_sda_lo = 0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(x);
    ack = !x;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit ack_it);
    for (int i = 7; i >= 0; i--) recv_bit(b[i]);
    send_bit(!ack_it);
  endtask

  task automatic i2c_write(input logic [6:0] a, input logic [7:0] sub, input int n,
                           input logic [23:0] d, output bit ok);
    bit ack;
    i2c_start();
    send_byte({a, 1'b0}, ack); ok = ack;
    if (ack) begin
      send_byte(sub, ack); ok &= ack;
      for (int i = 0; i < n; i++) begin send_byte(d[23-8*i -: 8], ack); ok &= ack; end
    end
    i2c_stop();
  endtask

  task automatic i2c_read(input logic [7:0] sub, input int n, output logic [23:0] d);
    bit ack, ok;
    logic [7:0] b;
    i2c_write(dev, sub, 0, 24'h0, ok);
    d = '0;
    i2c_start();
    send_byte({dev, 1'b1}, ack);
    for (int i = 0; i < n; i++) begin recv_byte(b, i != n-1); d[23-8*i -: 8] = b; end
    i2c_stop();
  endtask

  task automatic do_reset(input logic [1:0] s);
    rst_n = 0; strap = s; tick(5);
    for (int k = 0; k < 4; k++) for (int a = 0; a < 256; a++) expm[k][a] = 8'h00;
    rst_n = 1; tick(5);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] rd;
    bit ok;
    int s0;
    do_reset(2'b00);

    // reset state
    chk(!scl_oe && !sda_oe && strobe == 0, "R2 R8 reset idle", {scl_oe, sda_oe, strobe}, 0);
    i2c_read(FE, 1, rd);
    chk(rd[23:16] == 8'h0F, "R5 mask reset", rd[23:16], 8'h0F);
    i2c_read(FF, 1, rd);
    chk(rd[23:16] == 8'h00, "R7 select reset", rd[23:16], 8'h00);

    // vector table: mask then single write
    for (int i = 0; i < 6; i++) begin
      logic [3:0] m; logic [7:0] s, d;
      logic [31:0] act, exp;
      {m, s, d} = VEC[i];
      i2c_write(dev, FE, 1, {m, 4'h0, 16'h0} >> 4, ok);
      i2c_write(dev, s, 1, {d, 16'h0}, ok);
      for (int k = 0; k < 4; k++) if (m[k]) expm[k][s] = d;
      for (int k = 0; k < 4; k++) begin act[k*8 +: 8] = mem[k][s]; exp[k*8 +: 8] = expm[k][s]; end
      chk(ok && act == exp, "R3 R4 R5 vector", act, exp);
    end

    // auto-increment writes, distinct per core
    i2c_write(dev, FE, 1, 24'h020000, ok);
    i2c_write(dev, 8'h30, 3, 24'h112233, ok);
    i2c_write(dev, FE, 1, 24'h040000, ok);
    i2c_write(dev, 8'h30, 2, 24'h445500, ok);
    chk(ok && mem[1][8'h32] == 8'h33 && mem[2][8'h31] == 8'h55 && mem[0][8'h30] == 8'h00,
        "R3 auto-increment", {mem[1][8'h32], mem[2][8'h31]}, 16'h3355);

    // read select priority and clear of mask
    i2c_write(dev, FF, 1, 24'h060000, ok);
    i2c_read(8'h30, 3, rd);
    chk(rd == 24'h112233, "R7 R9 lowest select, multi-byte read", rd, 24'h112233);
    i2c_read(FE, 1, rd);
    chk(rd[23:16] == 8'h00, "R6 FF write clears mask", rd[23:16], 0);
    i2c_write(dev, FF, 1, 24'h040000, ok);
    i2c_read(8'h30, 3, rd);
    chk(rd == 24'h445500, "R7 R9 core2 read", rd, 24'h445500);
    i2c_write(dev, FE, 1, 24'h050000, ok);
    i2c_read(FF, 1, rd);
    chk(rd[23:16] == 8'h00, "R6 FE write clears select", rd[23:16], 0);
    i2c_read(FE, 1, rd);
    chk(rd[23:16] == 8'h05, "R5 mask readback", rd[23:16], 5);
    i2c_read(8'h30, 1, rd);
    chk(rd[23:16] == 8'hFF, "R7 empty select returns FF", rd[23:16], 8'hFF);

    // wrong address
    s0 = n_strobe;
    i2c_write(7'h5D, 8'h60, 1, 24'hAB0000, ok);
    chk(!ok && n_strobe == s0, "R1 foreign address ignored", ok, 0);

    // stretch: masked core busy
    i2c_write(dev, FE, 1, 24'h010000, ok);
    busy = 4'b0001;
    s0 = n_strobe;
    i2c_start();
    send_byte({dev, 1'b0}, ok);
    send_byte(8'h40, ok);
    fork
      send_byte(8'h99, ok);
      begin
        wait (scl_oe);
        tick(200);
        chk(scl_oe && !scl_bus && n_strobe == s0, "R8 hold while busy", n_strobe - s0, 0);
        busy = 4'b0000;
      end
    join
    i2c_stop();
    chk(ok && mem[0][8'h40] == 8'h99 && n_strobe == s0 + 1, "R8 write after release",
        mem[0][8'h40], 8'h99);

    // busy on unmasked core only
    busy = 4'b0010;
    saw_stretch = 0;
    i2c_write(dev, 8'h41, 1, 24'h770000, ok);
    chk(!saw_stretch && mem[0][8'h41] == 8'h77, "R8 unmasked busy ignored", saw_stretch, 0);
    busy = 4'b0000;

    // stop mid-byte aborts
    s0 = n_strobe;
    i2c_start();
    send_byte({dev, 1'b0}, ok);
    send_byte(8'h50, ok);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    i2c_stop();
    tick(20);
    chk(n_strobe == s0 && mem[0][8'h50] == 8'h00, "R2 stop aborts byte", n_strobe - s0, 0);
    i2c_write(dev, 8'h50, 1, 24'hC30000, ok);
    chk(ok && mem[0][8'h50] == 8'hC3, "R2 next transaction", mem[0][8'h50], 8'hC3);

    // strap change across reset
    do_reset(2'b10);
    i2c_write(7'h5C, 8'h60, 1, 24'h120000, ok);
    chk(!ok, "R1 old address after restrap", ok, 0);
    dev = 7'h5E;
    i2c_write(dev, 8'h60, 1, 24'h340000, ok);
    chk(ok && mem[3][8'h60] == 8'h34, "R1 strapped address", mem[3][8'h60], 8'h34);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule